// File: doc/BRIEF.md
# Timing-Arbitrated Open-Drain Line Repeater

This block joins two segments of one open-drain wire, such as the data or clock line of an I2C bus. Each segment, called side A and side B, gives the block a sampled level. The block can pull each side low through an active-high enable, and it never drives a line high. A released line reads high through its external pull-up. One instance handles one wire, so a complete bus buffer uses one instance for the data line and one for the clock line.

The direction is set by timing alone. Whichever side is first seen LOW wins, and the block then pulls the opposite side LOW. While that direction holds, the block ignores the side it is driving. Because of this, its own LOW cannot loop back and latch the winning side. When the winning side returns HIGH, the block releases the other side. It then waits through a parameterised hold-off so the pull-up can restore the line before a new race can start. A low enable input releases both drives at once and isolates the segments. Because the level is regenerated rather than offset, instances can be chained in series or joined in a star.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, and whenever the direction status reads idle (code 0), neither pull-low output is asserted.
- R2: With side B high, a LOW on side A asserts bPullLow and sets the status to A-to-B (code 1) three clock edges after the input changes: two synchronizer edges plus one control edge. aPullLow stays low.
- R3: With side A high, a LOW on side B asserts aPullLow and sets the status to B-to-A (code 2) three clock edges after the input changes. bPullLow stays low.
- R4: aPullLow and bPullLow are never asserted in the same cycle.
- R5: While a direction holds, the driven side's own LOW has no effect. The winning side is never driven, so when its external source releases, its line reads high and no latch-up occurs.
- R6: Three clock edges after the winning side's input returns HIGH, the block releases the losing side's pull-low and the status becomes hold-off (code 3).
- R7: Hold-off lasts HOLD_CYCLES clock cycles, during which both sides are ignored and nothing is driven. The status then returns to idle.
- R8: When both sides are first seen LOW in the same cycle, side A wins (status code 1, bPullLow asserted).
- R9: When enable is low, both pull-low outputs are clear from the next clock edge onward and the status is idle. No race starts until enable returns high.
- R10: If the losing side is still held LOW by its own segment when hold-off ends, that side wins on the next edge and the direction reverses. The short high glitch at the handoff then settles to LOW on the other side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High to allow repeating; low isolates both segments |
| aIn | input | 1 | Sampled level of side A (1 = high) |
| bIn | input | 1 | Sampled level of side B (1 = high) |
| aPullLow | output | 1 | Pull side A low when 1; released when 0 |
| bPullLow | output | 1 | Pull side B low when 1; released when 0 |
| dirState | output | 2 | Status: 0 idle, 1 A-to-B, 2 B-to-A, 3 hold-off |

## Verification
The assertions assume each line is a true wired-AND. A side's input can read low only when the block or that side's external device pulls it, and it reads high once both let go. The assertions also assume HOLD_CYCLES is at least the synchronizer depth, so a just-released line is seen high again before idle. The bench keeps to this by computing aIn and bIn from the block's own pull-low outputs combined with an external pull on each side. Every step then shows the real loop-back path, including the block's own LOW arriving back on the losing side. The bench changes input levels only on falling clock edges and holds them for whole cycles.

// File: rtl/od_rep_pkg.sv
package od_rep_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_A2B  = 2'd1,
    DIR_B2A  = 2'd2,
    DIR_HOLD = 2'd3
  } dir_e;

  typedef struct packed {
    logic pullA;
    logic pullB;
    logic dropAll;
  } pull_cmd_t;

endpackage

// File: rtl/od_rep_sync.sv
module od_rep_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut
);

  logic [LINES-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '1;
          else       stageQ[s] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '1;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/od_rep_ctrl.sv
module od_rep_ctrl
  import od_rep_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      aSync,
  input  logic      bSync,
  output pull_cmd_t cmd,
  output dir_e      state
);

  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

  dir_e             stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    cmd    = '0;
    if (!enable) begin
      stateD      = DIR_IDLE;
      cmd.dropAll = 1'b1;
    end else begin
      unique case (stateQ)
        DIR_IDLE: begin
          if (!aSync) begin
            stateD    = DIR_A2B;
            cmd.pullB = 1'b1;
          end else if (!bSync) begin
            stateD    = DIR_B2A;
            cmd.pullA = 1'b1;
          end
        end
        DIR_A2B: begin
          if (aSync) begin
            stateD      = DIR_HOLD;
            cntD        = CNT_LOAD;
            cmd.dropAll = 1'b1;
          end
        end
        DIR_B2A: begin
          if (bSync) begin
            stateD      = DIR_HOLD;
            cntD        = CNT_LOAD;
            cmd.dropAll = 1'b1;
          end
        end
        DIR_HOLD: begin
          if (cntQ == '0) stateD = DIR_IDLE;
          else            cntD   = cntQ - 1'b1;
        end
        default: stateD = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= DIR_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign state = stateQ;

  AST_LOCKOUT_A2B: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == DIR_A2B && !aSync && enable) |=> stateQ == DIR_A2B); // R5
  AST_LOCKOUT_B2A: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == DIR_B2A && !bSync && enable) |=> stateQ == DIR_B2A); // R5
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == DIR_HOLD && cntQ != '0 && enable) |=> stateQ == DIR_HOLD); // R7
  AST_TIE_A_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == DIR_IDLE && !aSync && !bSync && enable) |=> stateQ == DIR_A2B); // R8
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> stateQ == DIR_IDLE); // R9

endmodule

// File: rtl/od_rep_datapath.sv
module od_rep_datapath
  import od_rep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pull_cmd_t cmd,
  output logic      aPullLow,
  output logic      bPullLow
);

  logic aPullQ, bPullQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aPullQ <= 1'b0;
      bPullQ <= 1'b0;
    end else if (cmd.dropAll) begin
      aPullQ <= 1'b0;
      bPullQ <= 1'b0;
    end else if (cmd.pullA) begin
      aPullQ <= 1'b1;
    end else if (cmd.pullB) begin
      bPullQ <= 1'b1;
    end
  end

  assign aPullLow = aPullQ;
  assign bPullLow = bPullQ;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    !(aPullQ && bPullQ)); // R4

endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
  import od_rep_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       aIn,
  input  logic       bIn,
  output logic       aPullLow,
  output logic       bPullLow,
  output logic [1:0] dirState
);

  logic [1:0] syncLines;
  pull_cmd_t  cmd;
  dir_e       state;

  od_rep_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({bIn, aIn}), .syncOut(syncLines)
  );

  od_rep_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .aSync(syncLines[0]), .bSync(syncLines[1]),
    .cmd(cmd), .state(state)
  );

  od_rep_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .aPullLow(aPullLow), .bPullLow(bPullLow)
  );

  assign dirState = state;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == DIR_IDLE || state == DIR_HOLD) |-> (!aPullLow && !bPullLow)); // R1
  AST_A2B_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (state == DIR_A2B) |-> (bPullLow && !aPullLow)); // R2
  AST_B2A_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (state == DIR_B2A) |-> (aPullLow && !bPullLow)); // R3
  AST_DISABLE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!aPullLow && !bPullLow)); // R9

endmodule

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic aExtLow = 1'b0;
  logic bExtLow = 1'b0;
  logic aPullLow, bPullLow;
  logic [1:0] dirState;
  logic aIn, bIn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // wired-AND lines with pull-ups: low if anyone pulls
  assign aIn = !(aExtLow | aPullLow);
  assign bIn = !(bExtLow | bPullLow);

  od_line_repeater #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .aIn(aIn), .bIn(bIn),
    .aPullLow(aPullLow), .bPullLow(bPullLow), .dirState(dirState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settleIdle();
    aExtLow = 1'b0;
    bExtLow = 1'b0;
    cyc(3 + HOLD + 3);
  endtask

  task automatic testReset();
    chk("R1 reset dir", dirState, 0);
    chk("R1 reset aPull", aPullLow, 0);
    chk("R1 reset bPull", bPullLow, 0);
  endtask

  task automatic testAtoB();
    aExtLow = 1'b1;
    cyc(2);
    chk("R2 not yet bPull", bPullLow, 0);
    cyc(1);
    chk("R2 bPull", bPullLow, 1);
    chk("R2 dir", dirState, 1);
    chk("R2 aPull", aPullLow, 0);
    cyc(6);
    chk("R5 own low ignored dir", dirState, 1);
    chk("R5 aPull stays 0", aPullLow, 0);
    aExtLow = 1'b0;
    cyc(1);
    chk("R5 A line high, no latch", aIn, 1);
    cyc(2);
    chk("R6 bPull released", bPullLow, 0);
    chk("R6 dir hold", dirState, 3);
    cyc(HOLD - 1);
    chk("R7 still hold", dirState, 3);
    cyc(1);
    chk("R7 back to idle", dirState, 0);
    chk("R1 idle aPull", aPullLow, 0);
    chk("R1 idle bPull", bPullLow, 0);
  endtask

  task automatic testBtoA();
    bExtLow = 1'b1;
    cyc(3);
    chk("R3 aPull", aPullLow, 1);
    chk("R3 dir", dirState, 2);
    chk("R3 bPull", bPullLow, 0);
    chk("R4 one driver", aPullLow & bPullLow, 0);
    cyc(4);
    bExtLow = 1'b0;
    cyc(1);
    chk("R5 B line high, no latch", bIn, 1);
    cyc(2);
    chk("R6 aPull released", aPullLow, 0);
    cyc(HOLD);
    chk("R7 idle after hold", dirState, 0);
  endtask

  task automatic testTie();
    aExtLow = 1'b1;
    bExtLow = 1'b1;
    cyc(3);
    chk("R8 tie dir", dirState, 1);
    chk("R8 tie bPull", bPullLow, 1);
    chk("R8 tie aPull", aPullLow, 0);
    settleIdle();
    chk("R8 tie cleanup idle", dirState, 0);
  endtask

  task automatic testHandoff();
    aExtLow = 1'b1;
    cyc(3);
    chk("R10 first A2B", dirState, 1);
    bExtLow = 1'b1;           // far side also holds low
    cyc(3);
    aExtLow = 1'b0;           // near driver lets go
    cyc(3);
    chk("R10 hold entered", dirState, 3);
    chk("R7 nothing driven in hold", aPullLow | bPullLow, 0);
    chk("R10 glitch high on A", aIn, 1);
    cyc(HOLD);
    chk("R10 idle", dirState, 0);
    cyc(1);
    chk("R10 reversed dir", dirState, 2);
    chk("R10 A settles low", aIn, 0);
    bExtLow = 1'b0;
    cyc(3);
    chk("R10 A released", aPullLow, 0);
    cyc(HOLD + 3);
  endtask

  task automatic testEnable();
    aExtLow = 1'b1;
    cyc(3);
    chk("R9 pre A2B", dirState, 1);
    enable = 1'b0;
    cyc(1);
    chk("R9 drop bPull", bPullLow, 0);
    chk("R9 drop dir", dirState, 0);
    cyc(4);
    chk("R9 stays idle", dirState, 0);
    chk("R9 no drive", aPullLow | bPullLow, 0);
    enable = 1'b1;
    cyc(1);
    chk("R9 resumes", dirState, 1);
    settleIdle();
  endtask

  initial begin
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testAtoB();
    testBtoA();
    testTie();
    testHandoff();
    testEnable();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule